// File: doc/BRIEF.md
# Clock Rate Change Sequencer

This block carries out one clock rate change on a programmable PLL. A single start pulse hands it a target rate and a prepared control word. It writes the control word to the PLL control register with the power-down and bypass bits forced off. It then waits a fixed relock time, which is derived from the clock frequency parameter. After the wait it samples the PLL lock and error status once and reports one of three completion codes.

The core-clock variant also drives the divider of an interface clock that is derived from the PLL output. When the new rate is above a threshold, that divider is switched to divide-by-2 before the PLL is touched. It is switched back to divide-by-1 only after a relock that succeeds at a rate at or below the threshold. A failed change leaves the divider as it was. The plain variant, selected by a parameter, never touches the side divider.

Top module: `rcs_rate_seq`

## Requirements
- R1: During and right after reset, `done_o`, `ctrl_we_o` and `side_we_o` are low and `result_o` is 0.
- R2: Each accepted start produces exactly one `ctrl_we_o` pulse. Its `ctrl_data_o` equals the captured `cfg_i` with bit 0 (power-down) and bit 1 (bypass) cleared.
- R3: In the core variant, when `rate_i` is strictly above `THRESH_HZ`, one `side_we_o` pulse with `side_val_o` = 1 (divide-by-2) occurs in the cycle directly before the `ctrl_we_o` pulse.
- R4: `done_o` rises exactly WAIT_CYC + 3 clock cycles after the edge that samples `start_i`, where WAIT_CYC = (CLK_HZ / 1,000,000) × WAIT_US.
- R5: Lock and error are sampled once, at the end of the wait. If lock is low at that point, the code is 1 (timeout), whatever the error bit says.
- R6: If lock is high and error is high at the sample point, the code is 2 (invalid), and no divide-by-1 write is issued.
- R7: In the core variant, on success with `rate_i` at or below `THRESH_HZ` (equality included), one `side_we_o` pulse with `side_val_o` = 0 (divide-by-1) is issued in the same cycle as `done_o`, and the code is 0.
- R8: On success above the threshold the code is 0 and no divide-by-1 write is issued.
- R9: `done_o` is high for exactly one cycle, and `result_o` (0 ok, 1 timeout, 2 invalid) is valid in that cycle.
- R10: A `start_i` pulse that arrives after a start was accepted and before `done_o` rises is ignored: no further control write, no further completion, and the captured control word is unchanged.
- R11: With `CORE_VARIANT` = 0, `side_we_o` never rises, and the write, wait and check steps behave as in the core variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for one rate change |
| rate_i | input | RATE_W | Target rate in Hz, captured at start |
| cfg_i | input | CTRL_W | Prepared PLL control word, captured at start |
| lock_i | input | 1 | PLL lock status |
| err_i | input | 1 | PLL error status |
| ctrl_we_o | output | 1 | Control register write strobe |
| ctrl_data_o | output | CTRL_W | Control register write data |
| side_we_o | output | 1 | Interface clock divider write strobe |
| side_val_o | output | 1 | Divider code: 1 divide-by-2, 0 divide-by-1 |
| done_o | output | 1 | Completion pulse |
| result_o | output | 2 | Completion code |

## Verification
The completion of one change and the acceptance of the next can land in the same cycle. The sequencer is idle again while `done_o` is high, so a start driven in that cycle must open a fresh sequence. The bench provokes this by raising `start_i` exactly in the done cycle, then checks that a second control write follows with the new word and that a second completion follows. The divide-by-1 write also shares its cycle with `done_o`. This is judged by comparing the cycle stamps of the two strobes.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    // Control word bits that the PLL decodes as power-down and bypass
    localparam int unsigned PD_BIT  = 0;
    localparam int unsigned BYP_BIT = 1;

    // Interface clock divider codes
    localparam logic SIDE_DIV1 = 1'b0;
    localparam logic SIDE_DIV2 = 1'b1;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_INVALID = 2'd2
    } rcs_result_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAISE,
        ST_WRITE,
        ST_WAIT,
        ST_CHECK
    } rcs_state_e;

    typedef struct packed {
        rcs_result_e code;
        logic        lower;
    } rcs_verdict_t;

    function automatic int unsigned wait_cycles(int unsigned clk_hz, int unsigned wait_us);
        return (clk_hz / 1_000_000) * wait_us;
    endfunction

    // Lock is judged before the error bit; lowering the side divider only
    // follows a clean relock at or below the threshold.
    function automatic rcs_verdict_t judge(logic lock, logic err, logic core, logic above);
        rcs_verdict_t v;
        v.lower = 1'b0;
        if (!lock) begin
            v.code = RES_TIMEOUT;
        end else if (err) begin
            v.code = RES_INVALID;
        end else begin
            v.code  = RES_OK;
            v.lower = core && !above;
        end
        return v;
    endfunction

endpackage

// File: rtl/rcs_wait_timer.sv
module rcs_wait_timer #(
    parameter int unsigned CYCLES = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load_i) begin
            cnt_q <= CNT_W'(CYCLES - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) begin
                run_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign expired_o = run_q && (cnt_q == '0);

    assert_expire_once_R4: assert property (@(posedge clk) disable iff (rst)
        expired_o |=> !expired_o);

endmodule

// File: rtl/rcs_rate_cmp.sv
module rcs_rate_cmp #(
    parameter int unsigned RATE_W    = 32,
    parameter int unsigned THRESH_HZ = 500_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              above_o
);
    localparam logic [RATE_W-1:0] THRESH = RATE_W'(THRESH_HZ);

    always_ff @(posedge clk) begin
        if (rst) begin
            above_o <= 1'b0;
        end else if (capture_i) begin
            above_o <= (rate_i > THRESH);
        end
    end

endmodule

// File: rtl/rcs_rate_seq.sv
module rcs_rate_seq
    import rcs_pkg::*;
#(
    parameter int unsigned RATE_W       = 32,
    parameter int unsigned CTRL_W       = 32,
    parameter int unsigned CLK_HZ       = 200_000_000,
    parameter int unsigned WAIT_US      = 100,
    parameter int unsigned THRESH_HZ    = 500_000_000,
    parameter bit          CORE_VARIANT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CTRL_W-1:0] cfg_i,
    input  logic              lock_i,
    input  logic              err_i,
    output logic              ctrl_we_o,
    output logic [CTRL_W-1:0] ctrl_data_o,
    output logic              side_we_o,
    output logic              side_val_o,
    output logic              done_o,
    output logic [1:0]        result_o
);
    localparam int unsigned WAIT_CYC = wait_cycles(CLK_HZ, WAIT_US);

    rcs_state_e        state_q;
    logic [CTRL_W-1:0] cfg_q;
    logic [CTRL_W-1:0] clean_word;
    logic              above;
    logic              accept;
    logic              expired;
    rcs_verdict_t      verdict;
    rcs_result_e       result_q;

    assign accept = (state_q == ST_IDLE) && start_i;

    rcs_rate_cmp #(
        .RATE_W    (RATE_W),
        .THRESH_HZ (THRESH_HZ)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .capture_i (accept),
        .rate_i    (rate_i),
        .above_o   (above)
    );

    rcs_wait_timer #(
        .CYCLES (WAIT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (state_q == ST_WRITE),
        .expired_o (expired)
    );

    always_comb begin
        clean_word          = cfg_q;
        clean_word[PD_BIT]  = 1'b0;
        clean_word[BYP_BIT] = 1'b0;
    end

    assign verdict = judge(lock_i, err_i, CORE_VARIANT, above);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '0;
            ctrl_we_o   <= 1'b0;
            ctrl_data_o <= '0;
            side_we_o   <= 1'b0;
            side_val_o  <= SIDE_DIV1;
            done_o      <= 1'b0;
            result_q    <= RES_OK;
        end else begin
            ctrl_we_o <= 1'b0;
            side_we_o <= 1'b0;
            done_o    <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        cfg_q   <= cfg_i;
                        state_q <= ST_RAISE;
                    end
                end
                ST_RAISE: begin
                    if (CORE_VARIANT && above) begin
                        side_we_o  <= 1'b1;
                        side_val_o <= SIDE_DIV2;
                    end
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    ctrl_we_o   <= 1'b1;
                    ctrl_data_o <= clean_word;
                    state_q     <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (expired) begin
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    done_o   <= 1'b1;
                    result_q <= verdict.code;
                    if (verdict.lower) begin
                        side_we_o  <= 1'b1;
                        side_val_o <= SIDE_DIV1;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign result_o = result_q;

    assert_single_write_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we_o |=> !ctrl_we_o);

    assert_clean_word_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_we_o |-> (ctrl_data_o[BYP_BIT] == 1'b0 && ctrl_data_o[PD_BIT] == 1'b0));

    assert_raise_before_write_R3: assert property (@(posedge clk) disable iff (rst)
        (side_we_o && side_val_o == SIDE_DIV2) |=> ctrl_we_o);

    assert_timeout_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == 2'd1) |-> !$past(lock_i));

    assert_invalid_cause_R6: assert property (@(posedge clk) disable iff (rst)
        (done_o && result_o == 2'd2) |-> ($past(lock_i) && $past(err_i) && !side_we_o));

    assert_lower_on_success_R7: assert property (@(posedge clk) disable iff (rst)
        (side_we_o && side_val_o == SIDE_DIV1) |-> (done_o && result_o == 2'd0));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_code_legal_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (result_o != 2'd3));

    generate
        if (!CORE_VARIANT) begin : g_plain
            assert_no_side_R11: assert property (@(posedge clk) disable iff (rst)
                !side_we_o);
        end
    endgenerate

endmodule

// File: tb/rcs_rate_seq_tb_top.sv
`timescale 1ns/1ps
module rcs_rate_seq_tb_top;

    localparam int N      = 400;        // 200 MHz * 2 us
    localparam int THRESH = 500_000_000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] rate_i = '0;
    logic [31:0] cfg_i = '0;
    logic        lock_i = 1'b0;
    logic        err_i = 1'b0;

    logic        c_we, c_swe, c_sval, c_done;
    logic [31:0] c_data;
    logic [1:0]  c_res;
    logic        p_we, p_swe, p_sval, p_done;
    logic [31:0] p_data;
    logic [1:0]  p_res;

    always #2.5 clk = ~clk;

    rcs_rate_seq #(.WAIT_US(2), .CORE_VARIANT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .rate_i(rate_i), .cfg_i(cfg_i),
        .lock_i(lock_i), .err_i(err_i), .ctrl_we_o(c_we), .ctrl_data_o(c_data),
        .side_we_o(c_swe), .side_val_o(c_sval), .done_o(c_done), .result_o(c_res));

    rcs_rate_seq #(.WAIT_US(2), .CORE_VARIANT(1'b0)) dut_plain_i (
        .clk(clk), .rst(rst), .start_i(start_i), .rate_i(rate_i), .cfg_i(cfg_i),
        .lock_i(lock_i), .err_i(err_i), .ctrl_we_o(p_we), .ctrl_data_o(p_data),
        .side_we_o(p_swe), .side_val_o(p_sval), .done_o(p_done), .result_o(p_res));

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int ctrl_n = 0, ctrl_at = 0, raise_n = 0, raise_at = 0, lower_n = 0, lower_at = 0;
    int done_n = 0, done_at = 0, res = 0, pside_n = 0, pdone_n = 0, pres = 0;
    logic [31:0] word = '0, pword = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (c_we) begin ctrl_n <= ctrl_n + 1; ctrl_at <= cyc; word <= c_data; end
        if (c_swe && c_sval) begin raise_n <= raise_n + 1; raise_at <= cyc; end
        if (c_swe && !c_sval) begin lower_n <= lower_n + 1; lower_at <= cyc; end
        if (c_done) begin done_n <= done_n + 1; done_at <= cyc; res <= int'(c_res); end
        if (p_swe) pside_n <= pside_n + 1;
        if (p_we) pword <= p_data;
        if (p_done) begin pdone_n <= pdone_n + 1; pres <= int'(p_res); end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 100000);
            finish_run();
        end
    end

    // snapshots taken at launch
    int b_ctrl, b_raise, b_lower, b_done, b_pside, b_pdone, s_cyc;

    task automatic launch(input logic [31:0] rate, input logic [31:0] cfg,
                          input bit lk_early, input bit lk_late, input bit er, input bit poke);
        @(negedge clk);
        b_ctrl = ctrl_n; b_raise = raise_n; b_lower = lower_n;
        b_done = done_n; b_pside = pside_n; b_pdone = pdone_n;
        rate_i = rate; cfg_i = cfg; lock_i = lk_early; err_i = er;
        start_i = 1'b1;
        s_cyc = cyc;
        @(negedge clk);
        start_i = 1'b0;
        repeat (N / 2) @(negedge clk);
        lock_i = lk_late;
        if (poke) begin
            cfg_i = ~cfg; rate_i = 32'd100_000_000; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (c_done !== 1'b1) @(negedge clk);
        @(negedge clk);
        check("R9", "done width", int'(c_done), 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "done in reset", int'(c_done), 0);
        check("R1", "ctrl_we in reset", int'(c_we), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "side_we after reset", int'(c_swe), 0);
        check("R1", "result after reset", int'(c_res), 0);
    endtask

    task automatic t_high_ok();
        launch(32'd800_000_000, 32'h00F2_3A7F, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R2", "one write", ctrl_n - b_ctrl, 1);
        check("R2", "clean word", int'(word), int'(32'h00F2_3A7C));
        check("R3", "raise count", raise_n - b_raise, 1);
        check("R3", "raise before write", ctrl_at - raise_at, 1);
        check("R4", "done latency", done_at - s_cyc, N + 4);
        check("R8", "code ok", res, 0);
        check("R8", "no lower", lower_n - b_lower, 0);
        check("R11", "plain no side", pside_n - b_pside, 0);
        check("R11", "plain code", pres, 0);
        check("R11", "plain word", int'(pword), int'(32'h00F2_3A7C));
    endtask

    task automatic t_low_ok();
        launch(32'd300_000_000, 32'h0012_3456, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R3", "no raise low", raise_n - b_raise, 0);
        check("R7", "lower count", lower_n - b_lower, 1);
        check("R7", "lower with done", lower_at, done_at);
        check("R7", "code ok", res, 0);
        check("R11", "plain no side low", pside_n - b_pside, 0);
    endtask

    task automatic t_boundary();
        launch(THRESH, 32'h0000_1003, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R7", "equal: no raise", raise_n - b_raise, 0);
        check("R7", "equal: lower", lower_n - b_lower, 1);
        check("R2", "word bits cleared", int'(word), int'(32'h0000_1000));
        launch(THRESH + 1, 32'h0000_2001, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R3", "above by one: raise", raise_n - b_raise, 1);
        check("R8", "above by one: no lower", lower_n - b_lower, 0);
    endtask

    task automatic t_errors();
        launch(32'd900_000_000, 32'h0000_0F00, 1'b0, 1'b0, 1'b1, 1'b0);
        check("R5", "timeout code, err high", res, 1);
        check("R5", "timeout no lower", lower_n - b_lower, 0);
        check("R11", "plain timeout", pres, 1);
        launch(32'd200_000_000, 32'h0000_0E00, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R6", "invalid code", res, 2);
        check("R6", "invalid no lower", lower_n - b_lower, 0);
        launch(32'd200_000_000, 32'h0000_0D00, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R5", "timeout low rate no lower", lower_n - b_lower, 0);
    endtask

    task automatic t_sample_once();
        launch(32'd400_000_000, 32'h0000_0C00, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R5", "lock late only: ok", res, 0);
        launch(32'd400_000_000, 32'h0000_0B00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5", "lock lost late: timeout", res, 1);
    endtask

    task automatic t_ignore();
        launch(32'd700_000_000, 32'h0000_A5A4, 1'b1, 1'b1, 1'b0, 1'b1);
        repeat (N + 20) @(negedge clk);
        check("R10", "writes with poke", ctrl_n - b_ctrl, 1);
        check("R10", "dones with poke", done_n - b_done, 1);
        check("R10", "word kept", int'(word), int'(32'h0000_A5A4));
        check("R10", "plain dones with poke", pdone_n - b_pdone, 1);
    endtask

    task automatic t_back_to_back();
        launch(32'd600_000_000, 32'h0000_1110, 1'b1, 1'b1, 1'b0, 1'b0);
        b_ctrl = ctrl_n; b_done = done_n;
        // launch ended one cycle after the done pulse; start a run and
        // arm a second start exactly in its done cycle
        rate_i = 32'd600_000_000; cfg_i = 32'h0000_2220; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (c_done !== 1'b1) @(negedge clk);
        cfg_i = 32'h0000_3333; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (c_done !== 1'b1) @(negedge clk);
        @(negedge clk);
        check("R10", "start in done cycle accepted", ctrl_n - b_ctrl, 2);
        check("R2", "second word", int'(word), int'(32'h0000_3330));
        check("R9", "two completions", done_n - b_done, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_high_ok();
        t_low_ok();
        t_boundary();
        t_errors();
        t_sample_once();
        t_ignore();
        t_back_to_back();
        finish_run();
    end

endmodule